// File: doc/BRIEF.md
# Dual-Clock Timer Register Bridge

This block connects an 8-bit register bus, clocked by the system clock, to a 10-bit up-counter that runs on a faster, unrelated peripheral clock. Bus writes to the control and compare registers land in shadow registers in the system domain. The bus reads them back from there straight away. Each write is then carried to the counter through a falling-edge system-clock stage and one peripheral-clock stage.

Counter state and status flags travel the other way. They pass through one peripheral-clock stage, one rising-edge system-clock stage and one falling-edge system-clock stage before they reach the read multiplexer. A read of the count therefore returns a value that is a few clocks old.

The 10-bit count moves over the 8-bit bus through a 2-bit high-byte holding register, so that 10-bit transfers are atomic. A build parameter selects the synchronous variant. In that variant the counter runs on the system clock and every crossing stage is left out.

Top module: `tsb_bridge`

## Requirements
- R1: A write to the control register (address 0) or to a compare register (addresses 1, 2, 3) reads back on the very next bus cycle. A compare register returns the written byte. The control register returns bit 0, which is the run enable.
- R2: Bits 7..1 of the control register and all bits of address 7 always read 0.
- R3: Writing address 5 loads the 2-bit high holding register, and a read of address 5 returns it in bits 1..0. A write to a compare register stores {holding, byte}, and a write to address 4 loads the counter with {holding, byte}. A read of address 4 with bus_rd high returns the low count byte and copies the high count bits of that same value into the holding register at the end of that cycle.
- R4: Count and flag reads lag the counter. A read in the cycle right after a counter load still returns the old value. From the third cycle after the write edge on, the read returns the new value.
- R5: While the enable bit is 1, the counter rises by one on every peripheral clock edge and wraps from 1023 to 0. At any read, the returned 10-bit value v satisfies N-11 <= v <= N-1. Here N is the number of peripheral clock edges since the falling system-clock edge that followed the enabling write.
- R6: Flag bit i (i = 0..2, address 6) sets when the running counter equals the full 10-bit compare value i.
- R7: Flag bit 3 (address 6) sets when the running counter wraps from 1023 to 0.
- R8: Flags are sticky. Writing address 6 clears each flag whose bit is 1 in the written byte, and bits written as 0 have no effect. A set and a clear arriving together leave the flag set.
- R9: After reset, every address reads 0.
- R10: With the synchronous variant (ASYNC = 0), the counter runs on the system clock, and a counter load is visible to a read one cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System (bus) clock |
| rst_sys_n | input | 1 | Active-low synchronous reset, system domain |
| clk_per | input | 1 | Peripheral clock for the counter, more than twice clk_sys |
| rst_per_n | input | 1 | Active-low synchronous reset, peripheral domain |
| bus_wr | input | 1 | Write strobe, sampled on the rising system-clock edge |
| bus_rd | input | 1 | Read strobe; only affects the holding register on address 4 |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |

## Verification
The bench takes read data at the end of each bus cycle, which is where a bus master latches it. Shadow registers are compared in the cycle right after their write edge. For the count and the flags, the crossing path makes the arrival time uncertain. The bench therefore checks the old value in the first cycle after a load and the new value only from the third cycle on, or, for the synchronous variant, from the second cycle on. Flag reads are made at least four cycles after the stimulus. Free-running counts are compared against a window that the bench derives from its own count of peripheral clock edges, since the counter cannot be predicted to the exact edge.

// File: rtl/tsb_pkg.sv
`timescale 1ns/100ps
// Shared constants and the bundles that cross between the two clock domains.
package tsb_pkg;
    localparam int BUS_W = 8;
    localparam int CNT_W = 10;
    localparam int HI_W  = CNT_W - BUS_W;
    localparam int N_CMP = 3;
    localparam int N_FLG = N_CMP + 1;

    typedef enum logic [2:0] {
        RA_CTRL = 3'd0,
        RA_CMP0 = 3'd1,
        RA_CMP1 = 3'd2,
        RA_CMP2 = 3'd3,
        RA_CNTL = 3'd4,
        RA_CNTH = 3'd5,
        RA_FLAG = 3'd6,
        RA_NONE = 3'd7
    } reg_addr_e;

    // Control traffic from the bus to the counter
    typedef struct packed {
        logic                        en;
        logic [N_CMP-1:0][CNT_W-1:0] cmp;
        logic                        ld_tgl;
        logic [CNT_W-1:0]            ld_val;
        logic                        clr_tgl;
        logic [N_FLG-1:0]            clr_mask;
    } ctl_bus_t;

    // Counter state returning to the bus
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [N_FLG-1:0] flg;
    } sts_bus_t;
endpackage

// File: rtl/tsb_in_sync.sv
`timescale 1ns/100ps
// Input crossing: shadow bundle -> falling-edge system stage -> one peripheral stage.
// Assumes clk_sys is below half of clk_per, so that each half-cycle value is seen
// by at least two peripheral edges. Load and clear requests travel as toggles.
// ASYNC = 0 bypasses both stages.
module tsb_in_sync
    import tsb_pkg::*;
#(
    parameter int ASYNC = 1
) (
    input  logic     clk_sys,
    input  logic     rst_sys_n,
    input  logic     clk_per,
    input  logic     rst_per_n,
    input  ctl_bus_t ctl_i,
    output ctl_bus_t ctl_o
);
    generate
        if (ASYNC != 0) begin : g_async
            ctl_bus_t half_q;
            ctl_bus_t per_q;

            // Half-cycle stage: hold the shadow over the falling system edge
            always_ff @(negedge clk_sys) begin
                if (!rst_sys_n) half_q <= '0;
                else            half_q <= ctl_i;
            end

            // Peripheral stage: hand the bundle to the counter domain
            always_ff @(posedge clk_per) begin
                if (!rst_per_n) per_q <= '0;
                else            per_q <= half_q;
            end

            assign ctl_o = per_q;
        end else begin : g_sync
            assign ctl_o = ctl_i;
        end
    endgenerate
endmodule

// File: rtl/tsb_out_sync.sv
`timescale 1ns/100ps
// Output crossing: counter state -> peripheral stage -> rising system stage ->
// falling system stage -> read mux. The read value therefore lags the counter
// by a bounded number of clocks. ASYNC = 0 passes the state straight through.
module tsb_out_sync
    import tsb_pkg::*;
#(
    parameter int ASYNC = 1
) (
    input  logic     clk_sys,
    input  logic     rst_sys_n,
    input  logic     clk_per,
    input  logic     rst_per_n,
    input  sts_bus_t sts_i,
    output sts_bus_t sts_o
);
    generate
        if (ASYNC != 0) begin : g_async
            sts_bus_t per_q;
            sts_bus_t sys_q;
            sts_bus_t half_q;

            // Peripheral stage: freeze counter state on its own clock
            always_ff @(posedge clk_per) begin
                if (!rst_per_n) per_q <= '0;
                else            per_q <= sts_i;
            end

            // Rising system stage: bring the state into the bus domain
            always_ff @(posedge clk_sys) begin
                if (!rst_sys_n) sys_q <= '0;
                else            sys_q <= per_q;
            end

            // Falling system stage: value the read mux presents
            always_ff @(negedge clk_sys) begin
                if (!rst_sys_n) half_q <= '0;
                else            half_q <= sys_q;
            end

            assign sts_o = half_q;
        end else begin : g_sync
            assign sts_o = sts_i;
        end
    endgenerate
endmodule

// File: rtl/tsb_core.sv
`timescale 1ns/100ps
// Counter core: 10-bit up-counter with compare-match and wrap flags.
// Assumes its control bundle is already in its own clock domain. A change of a
// request toggle marks a load or a flag-clear event. Set wins over clear.
module tsb_core
    import tsb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  ctl_bus_t ctl,
    output sts_bus_t sts
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             ld_seen;
    logic             clr_seen;
    logic [CNT_W-1:0] cnt_q;
    logic [N_FLG-1:0] flg_q;
    logic [N_FLG-1:0] hit;
    logic [N_FLG-1:0] clr_vec;
    logic             ld_evt;
    logic             clr_evt;
    logic             run;

    assign ld_evt  = ctl.ld_tgl ^ ld_seen;
    assign clr_evt = ctl.clr_tgl ^ clr_seen;
    assign run     = ctl.en && !ld_evt;
    assign clr_vec = clr_evt ? ctl.clr_mask : '0;

    // Match detection, one comparator per compare register
    generate
        for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
            assign hit[i] = run && (cnt_q == ctl.cmp[i]);
        end
    endgenerate
    assign hit[N_FLG-1] = run && (cnt_q == CNT_MAX);

    // Count, load and remember the last request toggles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            ld_seen  <= 1'b0;
            clr_seen <= 1'b0;
        end else begin
            ld_seen  <= ctl.ld_tgl;
            clr_seen <= ctl.clr_tgl;
            if (ld_evt)      cnt_q <= ctl.ld_val;
            else if (ctl.en) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Sticky flags with write-one clear
    always_ff @(posedge clk) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= (flg_q & ~clr_vec) | hit;
    end

    assign sts.cnt = cnt_q;
    assign sts.flg = flg_q;

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.en && !ld_evt) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
    assert_cmp0_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.en && !ld_evt && cnt_q == ctl.cmp[0]) |=> flg_q[0]);
    assert_wrap_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.en && !ld_evt && cnt_q == CNT_MAX) |=> (flg_q[N_FLG-1] && cnt_q == '0));
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_q[0] && !(clr_evt && ctl.clr_mask[0])) |=> flg_q[0]);
    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && ctl.clr_mask[1] && !hit[1]) |=> !flg_q[1]);
endmodule

// File: rtl/tsb_bridge.sv
`timescale 1ns/100ps
// Top: bus-side shadow registers, request toggles, high-byte holding register
// and the read mux. Assumes clk_sys < clk_per / 2 when ASYNC = 1.
// ASYNC = 0 runs the counter on clk_sys with no crossing stages.
module tsb_bridge
    import tsb_pkg::*;
#(
    parameter int ASYNC = 1
) (
    input  logic             clk_sys,
    input  logic             rst_sys_n,
    input  logic             clk_per,
    input  logic             rst_per_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [2:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata
);
    ctl_bus_t         sh_q;
    ctl_bus_t         ctl_core;
    sts_bus_t         sts_core;
    sts_bus_t         sts_rd;
    logic [HI_W-1:0]  hold_q;
    logic             core_clk;
    logic             core_rst_n;
    reg_addr_e        addr;

    assign addr       = reg_addr_e'(bus_addr);
    assign core_clk   = (ASYNC != 0) ? clk_per : clk_sys;
    assign core_rst_n = (ASYNC != 0) ? rst_per_n : rst_sys_n;

    // Shadow registers, request toggles and the holding register
    always_ff @(posedge clk_sys) begin
        if (!rst_sys_n) begin
            sh_q   <= '0;
            hold_q <= '0;
        end else if (bus_wr) begin
            case (addr)
                RA_CTRL: sh_q.en <= bus_wdata[0];
                RA_CNTL: begin
                    sh_q.ld_val <= {hold_q, bus_wdata};
                    sh_q.ld_tgl <= ~sh_q.ld_tgl;
                end
                RA_CNTH: hold_q <= bus_wdata[HI_W-1:0];
                RA_FLAG: begin
                    sh_q.clr_mask <= bus_wdata[N_FLG-1:0];
                    sh_q.clr_tgl  <= ~sh_q.clr_tgl;
                end
                default: begin
                    for (int i = 0; i < N_CMP; i++) begin
                        if (bus_addr == 3'(int'(RA_CMP0) + i))
                            sh_q.cmp[i] <= {hold_q, bus_wdata};
                    end
                end
            endcase
        end else if (bus_rd && addr == RA_CNTL) begin
            hold_q <= sts_rd.cnt[CNT_W-1:BUS_W];
        end
    end

    // Read mux: shadows directly, counter state through the crossing
    always_comb begin
        bus_rdata = '0;
        case (addr)
            RA_CTRL: bus_rdata = {{(BUS_W-1){1'b0}}, sh_q.en};
            RA_CMP0: bus_rdata = sh_q.cmp[0][BUS_W-1:0];
            RA_CMP1: bus_rdata = sh_q.cmp[1][BUS_W-1:0];
            RA_CMP2: bus_rdata = sh_q.cmp[2][BUS_W-1:0];
            RA_CNTL: bus_rdata = sts_rd.cnt[BUS_W-1:0];
            RA_CNTH: bus_rdata = {{(BUS_W-HI_W){1'b0}}, hold_q};
            RA_FLAG: bus_rdata = {{(BUS_W-N_FLG){1'b0}}, sts_rd.flg};
            default: bus_rdata = '0;
        endcase
    end

    tsb_in_sync #(.ASYNC(ASYNC)) u_in (
        .clk_sys   (clk_sys),
        .rst_sys_n (rst_sys_n),
        .clk_per   (clk_per),
        .rst_per_n (rst_per_n),
        .ctl_i     (sh_q),
        .ctl_o     (ctl_core)
    );

    tsb_core u_core (
        .clk   (core_clk),
        .rst_n (core_rst_n),
        .ctl   (ctl_core),
        .sts   (sts_core)
    );

    tsb_out_sync #(.ASYNC(ASYNC)) u_out (
        .clk_sys   (clk_sys),
        .rst_sys_n (rst_sys_n),
        .clk_per   (clk_per),
        .rst_per_n (rst_per_n),
        .sts_i     (sts_core),
        .sts_o     (sts_rd)
    );

    assert_cmp_readback_R1: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
        (bus_wr && addr == RA_CMP0) |=> (addr != RA_CMP0 || bus_rdata == $past(bus_wdata)));
    assert_hold_readback_R3: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
        (bus_wr && addr == RA_CNTH) |=>
        (addr != RA_CNTH || bus_rdata == {{(BUS_W-HI_W){1'b0}}, $past(bus_wdata[HI_W-1:0])}));
    assert_unused_zero_R2: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
        $past(bus_wr) |-> (addr != RA_NONE || bus_rdata == '0));
endmodule

// File: tb/tb_tsb_bridge.sv
`timescale 1ns/100ps
module tb_tsb_bridge;
    logic       clk_sys = 1'b0;
    logic       clk_per = 1'b0;
    logic       rst_sys_n = 1'b0;
    logic       rst_per_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] rdata;
    logic [7:0] rdata_s;

    int n_chk = 0;
    int n_bad = 0;
    int pck_edges = 0;
    int samp_edges = 0;
    logic [7:0] rv;
    logic [7:0] rvs;
    bit done = 1'b0;

    tsb_bridge #(.ASYNC(1)) dut (
        .clk_sys(clk_sys), .rst_sys_n(rst_sys_n), .clk_per(clk_per), .rst_per_n(rst_per_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata));

    tsb_bridge #(.ASYNC(0)) dut_s (
        .clk_sys(clk_sys), .rst_sys_n(rst_sys_n), .clk_per(clk_per), .rst_per_n(rst_per_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_s));

    always #10 clk_sys = ~clk_sys;
    initial begin
        #1.3;
        forever #3.5 clk_per = ~clk_per;
    end
    always @(posedge clk_per) pck_edges = pck_edges + 1;

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic check_rng(input string tag, input int got, input int lo, input int hi);
        n_chk++;
        if (got < lo || got > hi) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d..%0d", tag, got, lo, hi);
        end
    endtask

    // All tasks start and end 1 ns after a rising system edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk_sys); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic strobe);
        bus_addr = a; bus_rd = strobe;
        #18;
        rv = rdata; rvs = rdata_s; samp_edges = pck_edges;
        @(posedge clk_sys); #1;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk_sys);
        #1;
    endtask

    initial begin
        logic [7:0] prev;
        int mark;
        int v;
        int nn;
        repeat (4) @(posedge clk_sys);
        #1;
        rst_sys_n = 1'b1; rst_per_n = 1'b1;

        // R9: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), 1'b0);
            check("R9 reset read", rv, 0);
        end

        // R1/R2: immediate read-back sweep of control and compare registers
        for (int a = 0; a < 4; a++) begin
            for (int d = 0; d < 256; d++) begin
                wr(3'(a), 8'(d));
                rd(3'(a), 1'b0);
                if (a == 0) check("R2 ctrl read-back", rv, d & 1);
                else        check("R1 compare read-back", rv, d);
            end
        end
        rd(3'd7, 1'b0);
        check("R2 unused address", rv, 0);

        // R3/R4/R10: counter loads, delayed visibility, holding register
        wr(3'd0, 8'h00);
        wr(3'd5, 8'h00);
        wr(3'd4, 8'h00);
        idle(4);
        prev = 8'h00;
        for (int h = 0; h < 4; h++) begin
            for (int k = 0; k < 3; k++) begin
                logic [7:0] lo;
                lo = 8'(8'h3C ^ (h * 8'h55) ^ (k * 8'h91));
                wr(3'd5, 8'(h));
                rd(3'd5, 1'b0);
                check("R3 holding read-back", rv, h);
                wr(3'd4, lo);
                rd(3'd4, 1'b0);
                check("R4 old count right after load", rv, prev);
                check("R10 sync old count at load edge", rvs, prev);
                rd(3'd4, 1'b0);
                check("R10 sync count one cycle later", rvs, lo);
                idle(1);
                rd(3'd4, 1'b1);
                check("R4 new count within three cycles", rv, lo);
                check("R10 sync count", rvs, lo);
                wr(3'd5, 8'h00);
                rd(3'd5, 1'b0);
                check("R3 holding cleared by write", rv, 0);
                rd(3'd4, 1'b1);
                rd(3'd5, 1'b0);
                check("R3 high bits captured by low read", rv, h);
                check("R3 sync high bits captured", rvs, h);
                prev = lo;
            end
        end

        // R5: free-running count against the bench's own edge count
        wr(3'd5, 8'h00);
        wr(3'd4, 8'h00);
        idle(4);
        wr(3'd0, 8'h01);
        @(negedge clk_sys);
        mark = pck_edges;
        @(posedge clk_sys); #1;
        for (int i = 0; i < 6; i++) begin
            idle(8);
            rd(3'd4, 1'b1);
            v = rv;
            nn = samp_edges - mark;
            rd(3'd5, 1'b0);
            v = v + 256 * rv;
            check_rng("R5 running count window", v, nn - 11, nn - 1);
        end
        wr(3'd0, 8'h00);

        // R6/R8: compare flags and write-one clear
        wr(3'd5, 8'h00); wr(3'd1, 8'hF5);
        wr(3'd5, 8'h01); wr(3'd2, 8'h00);
        wr(3'd5, 8'h02); wr(3'd3, 8'h00);
        wr(3'd5, 8'h00); wr(3'd4, 8'hF0);
        idle(4);
        wr(3'd6, 8'h0F);
        idle(4);
        rd(3'd6, 1'b0);
        check("R8 flags cleared", rv, 0);
        wr(3'd0, 8'h01);
        idle(40);
        wr(3'd0, 8'h00);
        idle(4);
        rd(3'd6, 1'b0);
        check("R6 compare 0 and 1 hit, 2 missed", rv, 8'h03);
        wr(3'd6, 8'h01);
        idle(4);
        rd(3'd6, 1'b0);
        check("R8 clear bit 0 only", rv, 8'h02);
        wr(3'd6, 8'h00);
        idle(4);
        rd(3'd6, 1'b0);
        check("R8 zero write has no effect", rv, 8'h02);
        wr(3'd6, 8'h02);
        idle(4);
        rd(3'd6, 1'b0);
        check("R8 clear bit 1", rv, 8'h00);

        // R7: wrap flag
        wr(3'd5, 8'h03); wr(3'd4, 8'hFC);
        idle(4);
        wr(3'd6, 8'h0F);
        idle(4);
        wr(3'd0, 8'h01);
        idle(20);
        wr(3'd0, 8'h00);
        idle(4);
        rd(3'd6, 1'b0);
        check("R7 wrap flag only", rv, 8'h08);
        rd(3'd4, 1'b1);
        v = rv;
        rd(3'd5, 1'b0);
        check("R7 high bits after wrap", rv, 0);
        check_rng("R7 low count after wrap", v, 1, 8'h7F);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_sys);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule